// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Master

This block loads a configuration image into a target FPGA through its byte-wide slave configuration port. An upstream buffer hands it the image one byte at a time over a valid/ready handshake. After a start command the block checks whether the port was left selected by an interrupted earlier load and, if so, runs a short abort sequence. It then pulses the target's active-low program line and waits for the target's init line to rise. It selects the port for writing, clocks in each byte, and gives a fixed number of extra clocks so the target can run its startup sequence. Finally it deselects the port and reports whether the target raised its done line.

Every time interval is counted in system clock cycles, derived from a clock-frequency parameter and microsecond parameters. The configuration clock is a divided strobe that rests high between pulses. The upstream side can mark a byte as the final one, or it can issue a separate finish command, either together with a byte or on its own. Init and done pass through a synchronizer whose depth is a parameter. A depth of zero removes it.

Top module: `fpga_cfg_master`

## Requirements
- R1: After reset and whenever the block is not busy, the configuration clock, chip select, read/write select and program outputs are all high, busy is low and in_ready_o is low. The status reads 0 after reset.
- R2: A start_i pulse while busy_o is high has no effect. The load in progress completes with the same result and the same configuration clock count as a load without it.
- R3: If cs_n_pad_i or rdwr_n_pad_i is low when start is accepted, the block drives read/write select high and chip select low. It gives ABORT_CLKS configuration clock pulses and then raises chip select before program falls. If both pads are high, no clock pulse occurs before program falls.
- R4: The program output stays low for exactly PROG_US × CLK_HZ/1e6 system cycles, and only while the port is deselected.
- R5: If init never rises, the block returns to idle with status 2 (not ready) exactly POLL_TRIES × POLL_STEP_US × CLK_HZ/1e6 cycles after program rises. It gives no write-mode clocks.
- R6: Once the synchronized init input is high, chip select and read/write select both go low. in_ready_o is high only while both are low and program is high.
- R7: An accepted byte appears on d_o in the same edge that drives the configuration clock low. d_o holds its value while the clock is low and at the following rising edge. There is exactly one rising edge per byte.
- R8: After the final byte, exactly START_CLKS further clock pulses occur with the port selected. Then chip select and read/write select go high. The clock pulses low only while chip select is low.
- R9: The status changes only when busy rises, where it clears to 0, or when busy falls. At the end of a load it is 1 if the synchronized done input is high and 3 otherwise.
- R10: A byte accepted with in_last_i or finish_i high is the final byte. finish_i with no valid byte in the load state starts the startup clocks at once.
- R11: Every configuration clock low phase lasts exactly CCLK_HALF system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (ignored while busy) |
| finish_i | input | 1 | End the data phase (with or without a byte) |
| in_valid_i | input | 1 | Upstream byte valid |
| in_data_i | input | DATA_W | Upstream byte |
| in_last_i | input | 1 | Marks the final byte |
| in_ready_o | output | 1 | Block accepts a byte this cycle |
| init_n_i | input | 1 | Target init line, high means ready for data |
| done_i | input | 1 | Target done line |
| cs_n_pad_i | input | 1 | Pad level of chip select, sampled at start |
| rdwr_n_pad_i | input | 1 | Pad level of read/write select, sampled at start |
| cclk_o | output | 1 | Configuration clock |
| cs_n_o | output | 1 | Active-low chip select |
| rdwr_n_o | output | 1 | Active-low read/write select (low = write) |
| prog_n_o | output | 1 | Active-low program pulse |
| d_o | output | DATA_W | Configuration data bus |
| busy_o | output | 1 | A sequence is running |
| status_o | output | 2 | 0 none, 1 success, 2 not ready, 3 configuration error |

## Verification
The data phase can end in the same cycle as a byte is accepted, because finish_i may arrive together with in_valid_i. The bench provokes this by raising finish_i on the final byte with in_last_i low, and also by issuing finish_i alone after the last byte. In both cases it requires the write-mode clock count to equal the byte count plus the startup pulses, and every captured byte to match. A start pulse injected in the middle of a load is also judged: the load must still produce the same clock count and result.

// File: rtl/cfgm_pkg.sv
`timescale 1ns/1ps
package cfgm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ABORT,
      ST_PROG,
      ST_POLL,
      ST_LOAD,
      ST_BYTE,
      ST_START,
      ST_CHECK
   } cfgm_state_e;

   typedef enum logic [1:0] {
      RES_NONE   = 2'd0,
      RES_OK     = 2'd1,
      RES_NOTRDY = 2'd2,
      RES_CFGERR = 2'd3
   } cfgm_result_e;

   function automatic int cfgm_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfgm_sync.sv
`timescale 1ns/1ps
// Input synchronizer; STAGES = 0 gives a plain wire.
module cfgm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial assert (STAGES >= 0) else $error("cfgm_sync: STAGES must be non-negative");

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d_i;
            else chain <= {chain[(STAGES>1 ? STAGES-2 : 0):0], d_i};
         end
         assign q_o = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cfgm_timer.sv
`timescale 1ns/1ps
// Loadable down-counter used for the program pulse and the poll steps.
module cfgm_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] value_i,
   output logic         expired_o
);
   initial assert (W >= 1) else $error("cfgm_timer: W must be at least 1");

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load_i)       cnt <= value_i;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired_o = (cnt == '0);
endmodule

// File: rtl/cfgm_cclk.sv
`timescale 1ns/1ps
// Configuration clock pulse generator: one low phase and one high phase
// of HALF cycles each per accepted go_i.
module cfgm_cclk #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic cclk_o,
   output logic active_o,
   output logic pulse_done_o
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   initial assert (HALF >= 1) else $error("cfgm_cclk: HALF must be at least 1");

   logic          hi_phase;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cclk_o   <= 1'b1;
         active_o <= 1'b0;
         hi_phase <= 1'b0;
         cnt      <= '0;
      end else if (!active_o) begin
         if (go_i) begin
            cclk_o   <= 1'b0;
            active_o <= 1'b1;
            hi_phase <= 1'b0;
            cnt      <= CW'(HALF - 1);
         end
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else if (!hi_phase) begin
         cclk_o   <= 1'b1;
         hi_phase <= 1'b1;
         cnt      <= CW'(HALF - 1);
      end else begin
         active_o <= 1'b0;
      end
   end

   assign pulse_done_o = active_o && hi_phase && (cnt == '0);
endmodule

// File: rtl/fpga_cfg_master.sv
`timescale 1ns/1ps
module fpga_cfg_master
   import cfgm_pkg::*;
#(
   parameter int CLK_HZ       = 100_000_000,
   parameter int DATA_W       = 8,
   parameter int PROG_US      = 100,
   parameter int POLL_STEP_US = 1000,
   parameter int POLL_TRIES   = 50,
   parameter int CCLK_HALF    = 2,
   parameter int ABORT_CLKS   = 4,
   parameter int START_CLKS   = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              finish_i,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic              in_last_i,
   output logic              in_ready_o,
   input  logic              init_n_i,
   input  logic              done_i,
   input  logic              cs_n_pad_i,
   input  logic              rdwr_n_pad_i,
   output logic              cclk_o,
   output logic              cs_n_o,
   output logic              rdwr_n_o,
   output logic              prog_n_o,
   output logic [DATA_W-1:0] d_o,
   output logic              busy_o,
   output logic [1:0]        status_o
);
   localparam int CYC_US   = CLK_HZ / 1_000_000;
   localparam int PROG_CYC = PROG_US * CYC_US;
   localparam int STEP_CYC = POLL_STEP_US * CYC_US;
   localparam int TMR_W    = $clog2(cfgm_max(PROG_CYC, STEP_CYC) + 1);
   localparam int PC_W     = $clog2(cfgm_max(ABORT_CLKS, START_CLKS) + 1);
   localparam int TRY_W    = $clog2(POLL_TRIES + 1);

   initial begin
      assert (CLK_HZ >= 1_000_000) else $error("fpga_cfg_master: CLK_HZ below 1 MHz");
      assert (PROG_CYC >= 1)       else $error("fpga_cfg_master: program pulse rounds to zero");
      assert (STEP_CYC >= 1)       else $error("fpga_cfg_master: poll step rounds to zero");
      assert (POLL_TRIES >= 1)     else $error("fpga_cfg_master: POLL_TRIES must be at least 1");
      assert (DATA_W >= 1)         else $error("fpga_cfg_master: DATA_W must be at least 1");
      assert (START_CLKS >= 1)     else $error("fpga_cfg_master: START_CLKS must be at least 1");
   end

   cfgm_state_e      state;
   logic [PC_W-1:0]  pcnt;
   logic [TRY_W-1:0] tries;
   logic             last_q;

   logic init_s, done_s;
   logic tmr_load, tmr_exp;
   logic [TMR_W-1:0] tmr_val;
   logic cg_go, cg_active, cg_done;
   logic pads_sel, pulses_done, poll_last;
   logic [PC_W-1:0] pulse_goal;

   cfgm_sync #(.STAGES(SYNC_STAGES)) u_sync_init (
      .clk(clk), .rst_n(rst_n), .d_i(init_n_i), .q_o(init_s));
   cfgm_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
      .clk(clk), .rst_n(rst_n), .d_i(done_i), .q_o(done_s));

   cfgm_timer #(.W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .value_i(tmr_val),
      .expired_o(tmr_exp));

   cfgm_cclk #(.HALF(CCLK_HALF)) u_cclk (
      .clk(clk), .rst_n(rst_n), .go_i(cg_go), .cclk_o(cclk_o),
      .active_o(cg_active), .pulse_done_o(cg_done));

   assign pads_sel    = !cs_n_pad_i || !rdwr_n_pad_i;
   assign pulse_goal  = (state == ST_ABORT) ? PC_W'(ABORT_CLKS) : PC_W'(START_CLKS);
   assign pulses_done = !cg_active && (pcnt == pulse_goal);
   assign poll_last   = (tries == TRY_W'(POLL_TRIES - 1));
   assign in_ready_o  = (state == ST_LOAD);
   assign busy_o      = (state != ST_IDLE);

   always_comb begin
      cg_go = 1'b0;
      case (state)
         ST_ABORT, ST_START: cg_go = !cg_active && (pcnt != pulse_goal);
         ST_LOAD:            cg_go = in_valid_i;
         default:            cg_go = 1'b0;
      endcase
   end

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = TMR_W'(PROG_CYC - 1);
      case (state)
         ST_IDLE:  tmr_load = start_i && !pads_sel;
         ST_ABORT: tmr_load = pulses_done;
         ST_PROG: begin
            tmr_load = tmr_exp;
            tmr_val  = TMR_W'(STEP_CYC - 1);
         end
         ST_POLL: begin
            tmr_load = tmr_exp && !init_s && !poll_last;
            tmr_val  = TMR_W'(STEP_CYC - 1);
         end
         default: tmr_load = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cs_n_o   <= 1'b1;
         rdwr_n_o <= 1'b1;
         prog_n_o <= 1'b1;
         d_o      <= '0;
         status_o <= RES_NONE;
         pcnt     <= '0;
         tries    <= '0;
         last_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start_i) begin
               status_o <= RES_NONE;
               if (pads_sel) begin
                  state    <= ST_ABORT;
                  rdwr_n_o <= 1'b1;
                  cs_n_o   <= 1'b0;
                  pcnt     <= '0;
               end else begin
                  state    <= ST_PROG;
                  prog_n_o <= 1'b0;
               end
            end
            ST_ABORT: begin
               if (pulses_done) begin
                  cs_n_o   <= 1'b1;
                  prog_n_o <= 1'b0;
                  state    <= ST_PROG;
               end else if (cg_go) begin
                  pcnt <= pcnt + 1'b1;
               end
            end
            ST_PROG: if (tmr_exp) begin
               prog_n_o <= 1'b1;
               tries    <= '0;
               state    <= ST_POLL;
            end
            ST_POLL: begin
               if (init_s) begin
                  cs_n_o   <= 1'b0;
                  rdwr_n_o <= 1'b0;
                  state    <= ST_LOAD;
               end else if (tmr_exp) begin
                  if (poll_last) begin
                     status_o <= RES_NOTRDY;
                     state    <= ST_IDLE;
                  end else begin
                     tries <= tries + 1'b1;
                  end
               end
            end
            ST_LOAD: begin
               if (in_valid_i) begin
                  d_o    <= in_data_i;
                  last_q <= in_last_i || finish_i;
                  state  <= ST_BYTE;
               end else if (finish_i) begin
                  pcnt  <= '0;
                  state <= ST_START;
               end
            end
            ST_BYTE: if (cg_done) begin
               if (last_q) begin
                  pcnt  <= '0;
                  state <= ST_START;
               end else begin
                  state <= ST_LOAD;
               end
            end
            ST_START: begin
               if (pulses_done) begin
                  cs_n_o   <= 1'b1;
                  rdwr_n_o <= 1'b1;
                  state    <= ST_CHECK;
               end else if (cg_go) begin
                  pcnt <= pcnt + 1'b1;
               end
            end
            ST_CHECK: begin
               status_o <= done_s ? RES_OK : RES_CFGERR;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfgm_checker.sv
`timescale 1ns/1ps
module cfgm_checker #(
   parameter int HALF   = 2,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cclk_o,
   input logic              cs_n_o,
   input logic              rdwr_n_o,
   input logic              prog_n_o,
   input logic [DATA_W-1:0] d_o,
   input logic              busy_o,
   input logic [1:0]        status_o,
   input logic              in_ready_o
);
   logic [15:0] lowcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lowcnt <= '0;
      else if (!cclk_o) lowcnt <= lowcnt + 1'b1;
      else              lowcnt <= '0;
   end

   a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && rdwr_n_o && prog_n_o && cclk_o && !in_ready_o));

   a_r3_abort_before_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && rdwr_n_o) |-> (prog_n_o && status_o == 2'd0));

   a_r4_prog_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n_o |-> (cs_n_o && rdwr_n_o && cclk_o));

   a_r6_ready_in_write_mode: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o |-> (!cs_n_o && !rdwr_n_o && prog_n_o));

   a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cclk_o |=> $stable(d_o));

   a_r8_clk_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      !cclk_o |-> !cs_n_o);

   a_r9_status_at_edges: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_o) |-> ($rose(busy_o) || $fell(busy_o)));

   a_r11_low_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk_o) |-> (lowcnt == 16'(HALF)));
endmodule

bind fpga_cfg_master cfgm_checker #(.HALF(CCLK_HALF), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cclk_o(cclk_o), .cs_n_o(cs_n_o),
   .rdwr_n_o(rdwr_n_o), .prog_n_o(prog_n_o), .d_o(d_o), .busy_o(busy_o),
   .status_o(status_o), .in_ready_o(in_ready_o));

// File: tb/sim_fpga_cfg_master.sv
`timescale 1ns/1ps
module sim_fpga_cfg_master;
   localparam int CLK_HZ = 4_000_000;
   localparam int PROG_US = 3;
   localparam int STEP_US = 2;
   localparam int TRIES = 3;
   localparam int HALF = 2;
   localparam int NCLK = 4;
   localparam int CYC_US = CLK_HZ / 1_000_000;
   localparam int EXP_PROG = PROG_US * CYC_US;
   localparam int EXP_POLL = TRIES * STEP_US * CYC_US;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 0, finish_i = 0, in_valid_i = 0, in_last_i = 0, done_i = 0;
   logic [7:0] in_data_i = '0;
   logic in_ready_o, cclk_o, cs_n_o, rdwr_n_o, prog_n_o, busy_o, init_n_i;
   logic [7:0] d_o;
   logic [1:0] status_o;
   logic f_cs = 0, f_rw = 0, init_en = 0, mon_clr = 0;
   int init_dly = 0;

   int checks = 0, fails = 0;

   // monitor state
   logic prev_cclk = 1'b1, prog_seen = 0, prog_rel = 0;
   int ab_rises, wr_rises, bad_rise, lowrun, low_bad, prog_low, poll_cyc, since, ready_bad;
   logic [7:0] cap [64];

   always #2 clk = ~clk;   // 4 ns period

   assign init_n_i = init_en && prog_rel && (since >= init_dly);

   fpga_cfg_master #(.CLK_HZ(CLK_HZ), .PROG_US(PROG_US), .POLL_STEP_US(STEP_US),
      .POLL_TRIES(TRIES), .CCLK_HALF(HALF), .ABORT_CLKS(NCLK), .START_CLKS(NCLK),
      .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .finish_i(finish_i),
      .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
      .in_ready_o(in_ready_o), .init_n_i(init_n_i), .done_i(done_i),
      .cs_n_pad_i(cs_n_o & ~f_cs), .rdwr_n_pad_i(rdwr_n_o & ~f_rw),
      .cclk_o(cclk_o), .cs_n_o(cs_n_o), .rdwr_n_o(rdwr_n_o), .prog_n_o(prog_n_o),
      .d_o(d_o), .busy_o(busy_o), .status_o(status_o));

   always @(negedge clk) begin
      if (mon_clr) begin
         ab_rises = 0; wr_rises = 0; bad_rise = 0; lowrun = 0; low_bad = 0;
         prog_low = 0; poll_cyc = 0; since = 0; ready_bad = 0;
         prog_seen = 0; prog_rel = 0;
      end else begin
         if (cclk_o && !prev_cclk) begin
            if (lowrun != HALF) low_bad++;
            if (!cs_n_o && rdwr_n_o) ab_rises++;
            else if (!cs_n_o && !rdwr_n_o) begin
               if (wr_rises < 64) cap[wr_rises] = d_o;
               wr_rises++;
            end else bad_rise++;
         end
         lowrun = cclk_o ? 0 : lowrun + 1;
         if (!prog_n_o) begin prog_low++; prog_seen = 1; end
         else if (prog_seen) begin
            prog_rel = 1;
            since++;
            if (busy_o) poll_cyc++;
         end
         if (in_ready_o && (cs_n_o || rdwr_n_o)) ready_bad++;
      end
      prev_cclk = cclk_o;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
   endtask

   // mode 0: in_last_i on final byte; 1: finish_i with final byte; 2: finish_i alone
   task automatic run(input int r, input int n, input int mode, input logic dn,
                      input logic fc, input logic fr, input int idly, input logic poke);
      logic [7:0] exp_b [64];
      @(negedge clk);
      mon_clr = 1; done_i = dn; f_cs = fc; f_rw = fr;
      init_en = (idly >= 0); init_dly = (idly >= 0) ? idly : 0;
      @(negedge clk);
      mon_clr = 0; start_i = 1;
      @(negedge clk);
      start_i = 0; f_cs = 0; f_rw = 0;
      if (idly >= 0) begin
         for (int i = 0; i < n; i++) begin
            exp_b[i] = 8'((n * 37 + i * 53 + r * 11) & 8'hFF);
            for (int g = 0; g < (i + n) % 3; g++) @(negedge clk);
            in_valid_i = 1; in_data_i = exp_b[i];
            in_last_i = (i == n - 1) && (mode == 0);
            finish_i  = (i == n - 1) && (mode == 1);
            while (!in_ready_o) @(negedge clk);
            @(negedge clk);
            in_valid_i = 0; in_last_i = 0; finish_i = 0;
            if (poke && i == 0) begin start_i = 1; @(negedge clk); start_i = 0; end
         end
         if (mode == 2) begin
            while (!in_ready_o) @(negedge clk);
            finish_i = 1; @(negedge clk); finish_i = 0;
         end
      end
      while (busy_o) @(negedge clk);
      @(negedge clk);
      chk("R3 abort clock pulses", ab_rises, (fc || fr) ? NCLK : 0);
      chk("R4 program low cycles", prog_low, EXP_PROG);
      chk("R1 idle levels", {cclk_o, cs_n_o, rdwr_n_o, prog_n_o, in_ready_o}, 5'b11110);
      chk("R11 low phase width errors", low_bad, 0);
      chk("R8 clock pulses while deselected", bad_rise, 0);
      if (idly < 0) begin
         chk("R5 not-ready status", status_o, 2);
         chk("R5 poll window cycles", poll_cyc, EXP_POLL);
         chk("R5 no write clocks", wr_rises, 0);
      end else begin
         chk("R9 result status", status_o, dn ? 1 : 3);
         chk("R6 ready outside write mode", ready_bad, 0);
         if (mode == 0) chk("R8 write clocks bytes+startup", wr_rises, n + NCLK);
         else chk("R10 write clocks with finish", wr_rises, n + NCLK);
         if (poke) chk("R2 start during load ignored", wr_rises, n + NCLK);
         for (int i = 0; i < n && i < wr_rises; i++)
            chk("R7 captured byte", cap[i], exp_b[i]);
      end
   endtask

   initial begin
      #(4 * 150000);
      checks++; fails++;
      $display("FAIL R9 watchdog actual=busy expected=idle");
      summary();
      $finish;
   end

   initial begin
      mon_clr = 1;
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {cclk_o, cs_n_o, rdwr_n_o, prog_n_o}, 4'hF);
      chk("R1 reset busy/ready", {busy_o, in_ready_o}, 0);
      chk("R1 reset status", status_o, 0);
      rst_n = 1;
      mon_clr = 0;
      @(negedge clk);
      chk("R1 idle after reset", {cclk_o, cs_n_o, rdwr_n_o, prog_n_o, busy_o}, 5'b11110);
      begin
         int r = 0;
         for (int n = 1; n <= 6; n++) begin
            for (int m = 0; m < 3; m++) begin
               run(r, n, m, logic'((n + m) % 2 == 0), logic'(r % 2), logic'((r / 2) % 2),
                   (r % 5) * 5, logic'(n >= 2 && r % 3 == 0));
               r++;
            end
         end
         run(r, 0, 0, 1'b1, 1'b0, 1'b0, -1, 1'b0);
         run(r + 1, 0, 0, 1'b1, 1'b1, 1'b1, -1, 1'b0);
         run(r + 2, 4, 1, 1'b1, 1'b0, 1'b1, 0, 1'b1);
      end
      summary();
      $finish;
   end
endmodule